// File: doc/BRIEF.md
# Compact Immediate Constant Classifier

This block decides whether a word-wide constant can be carried as a compact immediate, made of an 8-bit payload plus a small form code. A constant qualifies when it is a single byte moved left to any bit position. It also qualifies when it repeats one byte in one of three patterns: the low byte of each half-word, the high byte of each half-word, or every byte of the word.

A compiler back end or an instruction-encoding stage presents one constant per cycle with a valid strobe. One clock edge later the block reports whether the constant is encodable, which form applies, the payload byte and, for the shifted form, the left-shift amount. Each constant maps to exactly one encoding. The replication forms are preferred over the shifted form. Within the shifted form, the shift is the smallest one that leaves a 1 in bit 0 of the payload. Zero always comes out as the shifted form with payload 0 and shift 0.

Top module: `imm_classifier`

## Requirements
- R1: `out_valid_o` is low after reset and, at each rising clock edge, takes the value `in_valid_i` had just before that edge.
- R2: A nonzero constant whose set bits all lie within 8 consecutive positions, and that matches no replication form, gives ok=1, form code 0, `shift_o` equal to the number of trailing zero bits, and `payload_o` equal to the constant shifted right by that amount (so payload bit 0 is 1). Shifts of up to 31, odd values included, are accepted.
- R3: A constant of the form 0x00XY00XY with XY nonzero gives ok=1, form code 1, payload XY, shift 0.
- R4: A constant of the form 0xXY00XY00 with XY nonzero gives ok=1, form code 2, payload XY, shift 0.
- R5: A constant of the form 0xXYXYXYXY with XY nonzero gives ok=1, form code 3, payload XY, shift 0.
- R6: The constant 0 gives ok=1, form code 0, payload 0, shift 0.
- R7: Any other constant, for example 0x00000101 or 0x80000001, gives ok=0 with form code, payload and shift all 0.
- R8: While `in_valid_i` is low, `ok_o`, `form_o`, `payload_o` and `shift_o` keep their values whatever `value_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Constant on `value_i` is to be classified |
| value_i | input | 32 | Constant to classify |
| out_valid_o | output | 1 | Result registers were loaded at the last edge |
| ok_o | output | 1 | Constant is encodable |
| form_o | output | 2 | 0 shifted byte, 1 low-byte pair, 2 high-byte pair, 3 byte splat |
| payload_o | output | 8 | Payload byte |
| shift_o | output | 5 | Left-shift amount (shifted form only) |

## Verification
Every result appears on the outputs at the first rising edge after the cycle in which `in_valid_i` was high. The bench therefore drives a constant at a falling edge and reads `out_valid_o` and the result fields at the next falling edge, half a period after that register edge. It then drops `in_valid_i`, puts a different constant on `value_i`, and reads again one cycle later. At that point `out_valid_o` must be low and the result fields must be unchanged. Expected values come from a bench model that searches every shift amount in turn, instead of counting trailing zeros.

// File: rtl/imm_pkg.sv
package imm_pkg;
  localparam int unsigned DEF_WORD_W = 32;
  localparam int unsigned DEF_BYTE_W = 8;

  typedef enum logic [1:0] {
    FORM_SHIFT   = 2'd0,
    FORM_LO_PAIR = 2'd1,
    FORM_HI_PAIR = 2'd2,
    FORM_SPLAT   = 2'd3
  } imm_form_e;
endpackage

// File: rtl/imm_shift_finder.sv
module imm_shift_finder #(
  parameter int unsigned WORD_W  = imm_pkg::DEF_WORD_W,
  parameter int unsigned BYTE_W  = imm_pkg::DEF_BYTE_W,
  parameter int unsigned SHIFT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0]  value_i,
  output logic               nonzero_o,
  output logic               fits_o,
  output logic [SHIFT_W-1:0] shift_o,
  output logic [BYTE_W-1:0]  payload_o
);
  logic [SHIFT_W-1:0] tz;
  logic [WORD_W-1:0]  aligned;

  // lowest set bit wins: scan downward so the last hit is the smallest index
  always_comb begin
    tz = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (value_i[i]) tz = SHIFT_W'(i);
    end
  end

  assign aligned   = value_i >> tz;
  assign nonzero_o = |value_i;
  assign fits_o    = (aligned[WORD_W-1:BYTE_W] == '0);
  assign shift_o   = tz;
  assign payload_o = aligned[BYTE_W-1:0];
endmodule

// File: rtl/imm_repl_matcher.sv
module imm_repl_matcher #(
  parameter int unsigned WORD_W = imm_pkg::DEF_WORD_W,
  parameter int unsigned BYTE_W = imm_pkg::DEF_BYTE_W
) (
  input  logic [WORD_W-1:0] value_i,
  output logic              splat_o,
  output logic              lo_pair_o,
  output logic              hi_pair_o,
  output logic [BYTE_W-1:0] byte0_o,
  output logic [BYTE_W-1:0] byte1_o
);
  localparam int unsigned HALF_W = 2 * BYTE_W;
  localparam int unsigned N_BYTE = WORD_W / BYTE_W;
  localparam int unsigned N_HALF = WORD_W / HALF_W;

  logic [BYTE_W-1:0] b0, b1;
  logic [N_BYTE-1:0] splat_hit;
  logic [N_HALF-1:0] lo_hit, hi_hit;

  assign b0 = value_i[BYTE_W-1:0];
  assign b1 = value_i[HALF_W-1:BYTE_W];

  for (genvar g = 0; g < N_BYTE; g++) begin : g_byte
    assign splat_hit[g] = (value_i[g*BYTE_W +: BYTE_W] == b0);
  end

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    logic [HALF_W-1:0] lane;
    assign lane      = value_i[h*HALF_W +: HALF_W];
    assign lo_hit[h] = (lane == {{BYTE_W{1'b0}}, b0});
    assign hi_hit[h] = (lane == {b1, {BYTE_W{1'b0}}});
  end

  assign splat_o   = &splat_hit;
  assign lo_pair_o = &lo_hit;
  assign hi_pair_o = &hi_hit;
  assign byte0_o   = b0;
  assign byte1_o   = b1;
endmodule

// File: rtl/imm_form_select.sv
module imm_form_select #(
  parameter int unsigned BYTE_W  = imm_pkg::DEF_BYTE_W,
  parameter int unsigned SHIFT_W = $clog2(imm_pkg::DEF_WORD_W)
) (
  input  logic               nonzero_i,
  input  logic               fits_i,
  input  logic [SHIFT_W-1:0] tz_i,
  input  logic [BYTE_W-1:0]  aligned_i,
  input  logic               splat_i,
  input  logic               lo_pair_i,
  input  logic               hi_pair_i,
  input  logic [BYTE_W-1:0]  byte0_i,
  input  logic [BYTE_W-1:0]  byte1_i,
  output logic               ok_o,
  output imm_pkg::imm_form_e form_o,
  output logic [BYTE_W-1:0]  payload_o,
  output logic [SHIFT_W-1:0] shift_o
);
  import imm_pkg::*;

  // zero first, then replication (splat, low pair, high pair), then shifted byte
  always_comb begin
    ok_o      = 1'b0;
    form_o    = FORM_SHIFT;
    payload_o = '0;
    shift_o   = '0;
    if (!nonzero_i) begin
      ok_o = 1'b1;
    end else if (splat_i) begin
      ok_o      = 1'b1;
      form_o    = FORM_SPLAT;
      payload_o = byte0_i;
    end else if (lo_pair_i) begin
      ok_o      = 1'b1;
      form_o    = FORM_LO_PAIR;
      payload_o = byte0_i;
    end else if (hi_pair_i) begin
      ok_o      = 1'b1;
      form_o    = FORM_HI_PAIR;
      payload_o = byte1_i;
    end else if (fits_i) begin
      ok_o      = 1'b1;
      payload_o = aligned_i;
      shift_o   = tz_i;
    end
  end
endmodule

// File: rtl/imm_classifier.sv
module imm_classifier #(
  parameter int unsigned WORD_W  = imm_pkg::DEF_WORD_W,
  parameter int unsigned BYTE_W  = imm_pkg::DEF_BYTE_W,
  parameter int unsigned SHIFT_W = $clog2(WORD_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [WORD_W-1:0]  value_i,
  output logic               out_valid_o,
  output logic               ok_o,
  output logic [1:0]         form_o,
  output logic [BYTE_W-1:0]  payload_o,
  output logic [SHIFT_W-1:0] shift_o
);
  import imm_pkg::*;

  logic               sh_nonzero, sh_fits;
  logic [SHIFT_W-1:0] sh_tz;
  logic [BYTE_W-1:0]  sh_payload;
  logic               rp_splat, rp_lo, rp_hi;
  logic [BYTE_W-1:0]  rp_b0, rp_b1;
  logic               sel_ok;
  imm_form_e          sel_form;
  logic [BYTE_W-1:0]  sel_payload;
  logic [SHIFT_W-1:0] sel_shift;

  imm_shift_finder #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .SHIFT_W(SHIFT_W)) u_shift (
    .value_i   (value_i),
    .nonzero_o (sh_nonzero),
    .fits_o    (sh_fits),
    .shift_o   (sh_tz),
    .payload_o (sh_payload)
  );

  imm_repl_matcher #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_repl (
    .value_i   (value_i),
    .splat_o   (rp_splat),
    .lo_pair_o (rp_lo),
    .hi_pair_o (rp_hi),
    .byte0_o   (rp_b0),
    .byte1_o   (rp_b1)
  );

  imm_form_select #(.BYTE_W(BYTE_W), .SHIFT_W(SHIFT_W)) u_sel (
    .nonzero_i (sh_nonzero),
    .fits_i    (sh_fits),
    .tz_i      (sh_tz),
    .aligned_i (sh_payload),
    .splat_i   (rp_splat),
    .lo_pair_i (rp_lo),
    .hi_pair_i (rp_hi),
    .byte0_i   (rp_b0),
    .byte1_i   (rp_b1),
    .ok_o      (sel_ok),
    .form_o    (sel_form),
    .payload_o (sel_payload),
    .shift_o   (sel_shift)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      ok_o        <= 1'b0;
      form_o      <= '0;
      payload_o   <= '0;
      shift_o     <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        ok_o      <= sel_ok;
        form_o    <= sel_form;
        payload_o <= sel_payload;
        shift_o   <= sel_shift;
      end
    end
  end
endmodule

// File: rtl/imm_classifier_chk.sv
module imm_classifier_chk #(
  parameter int unsigned WORD_W  = imm_pkg::DEF_WORD_W,
  parameter int unsigned BYTE_W  = imm_pkg::DEF_BYTE_W,
  parameter int unsigned SHIFT_W = $clog2(WORD_W)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic [WORD_W-1:0]  value_i,
  input logic               out_valid_o,
  input logic               ok_o,
  input logic [1:0]         form_o,
  input logic [BYTE_W-1:0]  payload_o,
  input logic [SHIFT_W-1:0] shift_o
);
  localparam int unsigned N_BYTE = WORD_W / BYTE_W;
  localparam int unsigned N_HALF = WORD_W / (2 * BYTE_W);

  function automatic logic [WORD_W-1:0] rebuild(input logic [1:0] f,
                                                input logic [BYTE_W-1:0] p,
                                                input logic [SHIFT_W-1:0] s);
    case (f)
      2'd1:    rebuild = {N_HALF{{BYTE_W{1'b0}}, p}};
      2'd2:    rebuild = {N_HALF{p, {BYTE_W{1'b0}}}};
      2'd3:    rebuild = {N_BYTE{p}};
      default: rebuild = {{(WORD_W-BYTE_W){1'b0}}, p} << s;
    endcase
  endfunction

  // R1
  valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i));

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable({ok_o, form_o, payload_o, shift_o}));

  // R7
  reject_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !ok_o) |-> (form_o == 2'd0 && payload_o == '0 && shift_o == '0));

  // R2
  shift_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && ok_o && form_o == 2'd0 && payload_o != '0) |-> payload_o[0]);

  // R3 R4 R5
  repl_noshift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && ok_o && form_o != 2'd0) |-> (shift_o == '0 && payload_o != '0));

  // R6
  zero_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && value_i == '0) |=> (ok_o && form_o == 2'd0 && payload_o == '0 && shift_o == '0));

  // R2 R3 R4 R5
  rebuild_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (!ok_o || rebuild(form_o, payload_o, shift_o) == $past(value_i)));
endmodule

bind imm_classifier imm_classifier_chk #(
  .WORD_W(WORD_W), .BYTE_W(BYTE_W), .SHIFT_W(SHIFT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .value_i     (value_i),
  .out_valid_o (out_valid_o),
  .ok_o        (ok_o),
  .form_o      (form_o),
  .payload_o   (payload_o),
  .shift_o     (shift_o)
);

// File: tb/imm_classifier_bench.sv
`timescale 1ns/1ps
module imm_classifier_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] value = '0;
  logic        out_valid, ok;
  logic [1:0]  form;
  logic [7:0]  payload;
  logic [4:0]  shift;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  imm_classifier u_imm_classifier (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .value_i(value),
    .out_valid_o(out_valid), .ok_o(ok), .form_o(form),
    .payload_o(payload), .shift_o(shift)
  );

  // packed {ok, form, payload, shift}
  function automatic logic [15:0] ref_model(input logic [31:0] v);
    logic [7:0] b0, b1;
    b0 = v[7:0];
    b1 = v[15:8];
    if (v == 32'h0) return {1'b1, 2'd0, 8'h00, 5'd0};
    if (v == {b0, b0, b0, b0}) return {1'b1, 2'd3, b0, 5'd0};
    if (v == {8'h00, b0, 8'h00, b0}) return {1'b1, 2'd1, b0, 5'd0};
    if (v == {b1, 8'h00, b1, 8'h00}) return {1'b1, 2'd2, b1, 5'd0};
    for (int s = 0; s < 32; s++) begin
      logic [31:0] p;
      p = v >> s;
      if (p < 32'd256 && p[0] && ((p << s) == v)) return {1'b1, 2'd0, p[7:0], 5'(s)};
    end
    return 16'h0;
  endfunction

  function automatic string req_of(input logic [15:0] e, input logic [31:0] v);
    if (!e[15]) return "R7";
    if (v == 32'h0) return "R6";
    case (e[14:13])
      2'd1: return "R3";
      2'd2: return "R4";
      2'd3: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] v);
    logic [15:0] e;
    logic [15:0] held;
    e = ref_model(v);
    @(negedge clk);
    value = v;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    value = ~v ^ 32'h0000_0101;
    check("R1", 32'(out_valid), 32'd1, "out_valid after strobe");
    check(req_of(e, v), 32'({ok, form, payload, shift}), 32'(e), $sformatf("result for %h", v));
    held = {ok, form, payload, shift};
    @(negedge clk);
    check("R1", 32'(out_valid), 32'd0, "out_valid idle");
    check("R8", 32'({ok, form, payload, shift}), 32'(held), "hold while idle");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // reset state
    check("R1", 32'(out_valid), 32'd0, "out_valid in reset");
    check("R7", 32'({ok, form, payload, shift}), 32'd0, "result in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'(out_valid), 32'd0, "out_valid after reset");

    apply(32'h0000_0000);   // R6
    apply(32'h0000_0001);   // R2
    apply(32'hFF00_0000);   // R2 shift 24
    apply(32'h000F_E000);   // R2 odd shift 13
    apply(32'h8000_0000);   // R2 shift 31
    apply(32'h0000_0102);   // R2 payload 0x81 shift 1
    apply(32'hAB00_AB00);   // R4
    apply(32'h00FF_00FF);   // R3
    apply(32'h1212_1212);   // R5
    apply(32'hFFFF_FFFF);   // R5
    apply(32'h0000_0101);   // R7 span 9
    apply(32'h8000_0001);   // R7 wraparound
    apply(32'h00AB_00AC);   // R7 near R3
    apply(32'hAB00_AC00);   // R7 near R4

    for (int n = 0; n < 600; n++) begin
      logic [7:0]  b;
      logic [31:0] v;
      b = 8'($urandom);
      case ($urandom % 5)
        0: v = 32'(b) << ($urandom % 32);
        1: v = {8'h00, b, 8'h00, b};
        2: v = {b, 8'h00, b, 8'h00};
        3: v = {b, b, b, b};
        default: v = $urandom;
      endcase
      apply(v);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule